// File: doc/BRIEF.md
# PHY Control-Port Handshake Sequencer

This block sits between a host-side request interface and the narrow control port of a SerDes PHY whose register file is not memory-mapped. The host hands over one 16-bit PHY register address, optional write data and a read-or-write command. The block then runs the whole access as a chain of four-phase handshakes over one 20-bit control word and one acknowledge line shared by every phase.

A write takes three handshakes: address capture, data capture, then the write strobe. A read takes two: address capture, then the read strobe, with the read value taken from the PHY status data while the acknowledge is high. The acknowledge crosses into the block's clock through a two-stage synchronizer. It is sampled once every `POLL_GAP` cycles, and each wait gets at most `POLL_LIMIT` samples. A wait that runs out aborts the access, zeroes the control word and reports a timeout.

Top module: `phy_ctl_seq`

## Requirements
- R1: The control word places the address or data in bits 15:0, capture-address in bit 16, capture-data in bit 17, the write strobe in bit 18 and the read strobe in bit 19. At most one of bits 19:16 is high in any cycle, and a strobe bit is raised only after the acknowledge has been seen low.
- R2: Every access starts with an address phase. The address is first driven on bits 15:0 alone. Capture-address is then raised with the address held until the acknowledge is seen high, and dropped with the address still held until the acknowledge is seen low.
- R3: A write then drives the data on bits 15:0 and raises capture-data until the acknowledge is seen high. It drops capture-data until the acknowledge is seen low, raises the write strobe alone until the acknowledge is seen high, and drops it until the acknowledge is seen low. The control word then returns to zero.
- R4: A read raises the read strobe alone after the address phase. When the acknowledge is seen high, it stores `phy_rdata` on `rd_data`, drives the control word to zero and waits for the acknowledge to be seen low.
- R5: `phy_ack` is used only after two register stages and is examined once every `POLL_GAP` cycles during a wait.
- R6: A wait that has examined the acknowledge `POLL_LIMIT` times without seeing the expected level aborts the access. The control word goes to zero, `timed_out` is set and the block returns to idle. With the defaults (4, 10), a capture-address that is never acknowledged ends 40 cycles after the request is accepted.
- R7: A request (`req_valid` high for a cycle) is accepted only when `busy` is low. A request raised while `busy` is high is dropped and causes no PHY access.
- R8: `done` pulses high for exactly one cycle at the end of every access, whether it completes or times out. `timed_out` stays valid from that pulse until the next request is accepted, which clears it.
- R9: After a synchronous reset, the control word is zero, and `busy`, `done` and `timed_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pulse, taken only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| timed_out | output | 1 | Last access was aborted by a poll timeout |
| rd_data | output | 16 | Value returned by the last completed read |
| phy_ctl | output | 20 | Control word to the PHY (data field plus four strobes) |
| phy_ack | input | 1 | Acknowledge from the PHY, asynchronous |
| phy_rdata | input | 16 | Data field of the PHY status word |

## Verification
The in-line assertions check the following on every cycle:
- at most one strobe bit is high;
- the control word is zero while idle;
- the latched address cannot change during an access;
- the per-wait poll count stays inside its budget;
- `done` never lasts two cycles, and `timed_out` rises only together with `done`.

The order of the phases, the data captured by the PHY, the read value returned and the exact abort time depend on the PHY's answers. Only the bench scenarios can show these. The bench uses a PHY model with random acknowledge delays, an acknowledge held low, an acknowledge held high, and a request raised in the middle of a busy access.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_SET,
    ST_ADR_CAP,
    ST_ADR_REL,
    ST_DAT_SET,
    ST_DAT_CAP,
    ST_DAT_REL,
    ST_WR_STB,
    ST_WR_REL,
    ST_RD_STB,
    ST_RD_REL
  } seq_st_e;

  localparam int STROBE_N = 4;
  localparam int STB_CAPA = 0;
  localparam int STB_CAPD = 1;
  localparam int STB_WR   = 2;
  localparam int STB_RD   = 3;
endpackage

// File: rtl/phy_ctl_sync.sv
module phy_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/phy_ctl_poll.sv
module phy_ctl_poll #(
  parameter int POLL_GAP   = 4,
  parameter int POLL_LIMIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic active,
  output logic tick,
  output logic last
);
  localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam int TW = $clog2(POLL_LIMIT + 1);
  localparam logic [GW-1:0] GAP_RELOAD = GW'(POLL_GAP - 1);
  localparam logic [TW-1:0] LAST_TRY   = TW'(POLL_LIMIT - 1);

  logic [GW-1:0] gap_q;
  logic [TW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      gap_q   <= GAP_RELOAD;
      tries_q <= '0;
    end else if (active) begin
      if (gap_q == '0) begin
        gap_q <= GAP_RELOAD;
        if (tries_q != LAST_TRY) tries_q <= tries_q + 1'b1;
      end else begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end

  assign tick = active && (gap_q == '0);
  assign last = (tries_q == LAST_TRY);

  // R6: the poll count of one wait never passes its budget
  assert_poll_budget_R6: assert property (@(posedge clk) disable iff (rst)
    active |-> (tries_q < TW'(POLL_LIMIT)));
endmodule

// File: rtl/phy_ctl_fsm.sv
module phy_ctl_fsm
  import phy_ctl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [DATA_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic                       ack_s,
  input  logic                       tick,
  input  logic                       last,
  input  logic [DATA_W-1:0]          phy_rdata,
  output logic                       arm,
  output logic                       active,
  output logic [DATA_W+STROBE_N-1:0] ctl_word,
  output logic                       busy,
  output logic                       done,
  output logic                       timed_out,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int CW = DATA_W + STROBE_N;

  seq_st_e st_q, st_d;
  logic [DATA_W-1:0] addr_q, wdata_q, rd_q;
  logic              wr_q, done_q, err_q;
  logic [CW-1:0]     ctl_q, ctl_d;
  logic              fin, abort, sample, expect_hi, accept;

  function automatic logic [CW-1:0] pack(input logic [STROBE_N-1:0] stb,
                                         input logic [DATA_W-1:0] fld);
    return {stb, fld};
  endfunction

  always_comb begin
    unique case (st_q)
      ST_ADR_CAP, ST_DAT_CAP, ST_WR_STB, ST_RD_STB: expect_hi = 1'b1;
      default:                                       expect_hi = 1'b0;
    endcase
  end

  assign active = (st_q != ST_IDLE) && (st_q != ST_ADR_SET) && (st_q != ST_DAT_SET);
  assign accept = (st_q == ST_IDLE) && req_valid;

  always_comb begin
    st_d   = st_q;
    fin    = 1'b0;
    abort  = 1'b0;
    sample = 1'b0;
    case (st_q)
      ST_IDLE:    if (req_valid) st_d = ST_ADR_SET;
      ST_ADR_SET: st_d = ST_ADR_CAP;
      ST_DAT_SET: st_d = ST_DAT_CAP;
      default: begin
        if (tick) begin
          if (ack_s == expect_hi) begin
            case (st_q)
              ST_ADR_CAP: st_d = ST_ADR_REL;
              ST_ADR_REL: st_d = wr_q ? ST_DAT_SET : ST_RD_STB;
              ST_DAT_CAP: st_d = ST_DAT_REL;
              ST_DAT_REL: st_d = ST_WR_STB;
              ST_WR_STB:  st_d = ST_WR_REL;
              ST_RD_STB:  begin st_d = ST_RD_REL; sample = 1'b1; end
              default:    begin st_d = ST_IDLE;   fin    = 1'b1; end
            endcase
          end else if (last) begin
            st_d  = ST_IDLE;
            abort = 1'b1;
          end
        end
      end
    endcase
  end

  assign arm = (st_d != st_q);

  always_comb begin
    logic [DATA_W-1:0] a_src;
    a_src = (st_q == ST_IDLE) ? req_addr : addr_q;
    case (st_d)
      ST_ADR_SET: ctl_d = pack('0, a_src);
      ST_ADR_CAP: ctl_d = pack(STROBE_N'(1) << STB_CAPA, a_src);
      ST_ADR_REL: ctl_d = pack('0, a_src);
      ST_DAT_SET: ctl_d = pack('0, wdata_q);
      ST_DAT_CAP: ctl_d = pack(STROBE_N'(1) << STB_CAPD, wdata_q);
      ST_DAT_REL: ctl_d = pack('0, wdata_q);
      ST_WR_STB:  ctl_d = pack(STROBE_N'(1) << STB_WR, '0);
      ST_WR_REL:  ctl_d = pack('0, wdata_q);
      ST_RD_STB:  ctl_d = pack(STROBE_N'(1) << STB_RD, '0);
      default:    ctl_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      ctl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      done_q <= fin || abort;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        err_q   <= 1'b0;
      end
      if (abort)  err_q <= 1'b1;
      if (sample) rd_q  <= phy_rdata;
    end
  end

  assign ctl_word  = ctl_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign timed_out = err_q;
  assign rd_data   = rd_q;

  // R1: never two strobes at once
  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctl_q[CW-1:DATA_W]));
  // R6: idle means a quiet control port
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (ctl_q == '0));
  // R7: the captured request cannot change mid-access
  assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> $stable(addr_q));
  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R8: the timeout flag only appears with the end pulse
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> done_q);
endmodule

// File: rtl/phy_ctl_seq.sv
module phy_ctl_seq
  import phy_ctl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SYNC_STG   = 2,
  parameter int POLL_GAP   = 4,
  parameter int POLL_LIMIT = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [DATA_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       busy,
  output logic                       done,
  output logic                       timed_out,
  output logic [DATA_W-1:0]          rd_data,
  output logic [DATA_W+STROBE_N-1:0] phy_ctl,
  input  logic                       phy_ack,
  input  logic [DATA_W-1:0]          phy_rdata
);
  logic ack_s, tick, last, arm, active;

  phy_ctl_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_in(phy_ack), .sync_out(ack_s)
  );

  phy_ctl_poll #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .arm(arm), .active(active), .tick(tick), .last(last)
  );

  phy_ctl_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .ack_s(ack_s), .tick(tick), .last(last), .phy_rdata(phy_rdata),
    .arm(arm), .active(active), .ctl_word(phy_ctl),
    .busy(busy), .done(done), .timed_out(timed_out), .rd_data(rd_data)
  );
endmodule

// File: tb/phy_ctl_seq_tb.sv
module phy_ctl_seq_tb_top;
  localparam int GAP = 4;
  localparam int LIM = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, timed_out;
  logic [15:0] rd_data, phy_rdata;
  logic [19:0] phy_ctl;
  logic        phy_ack;

  always #2.5 clk = ~clk;

  phy_ctl_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIM)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .timed_out(timed_out), .rd_data(rd_data), .phy_ctl(phy_ctl),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  // ---------------- PHY model ----------------
  logic        stuck_lo = 1'b0, stuck_hi = 1'b0;
  logic        ack_lvl, want;
  int          cnt;
  logic [3:0]  prev_stb;
  logic [1:0]  phase;
  logic [15:0] lat_addr, lat_wdat, rd_val, noise;
  logic [15:0] phy_mem [0:255];
  int          viol_ord, viol_multi, txn, ndone;
  wire  [3:0]  stb = phy_ctl[19:16];

  assign phy_ack   = stuck_hi ? 1'b1 : (stuck_lo ? 1'b0 : ack_lvl);
  assign phy_rdata = (prev_stb[3] && ack_lvl) ? rd_val : noise;

  initial for (int i = 0; i < 256; i++) phy_mem[i] = 16'h1000 + 16'(i * 7);

  always @(posedge clk) begin
    if (rst) begin
      ack_lvl <= 1'b0; want <= 1'b0; cnt <= 0; prev_stb <= '0; phase <= '0;
      viol_ord <= 0; viol_multi <= 0; txn <= 0; noise <= '0;
      lat_addr <= '0; lat_wdat <= '0; rd_val <= '0;
    end else begin
      noise    <= 16'($urandom);
      prev_stb <= stb;
      if ($countones(stb) > 1) viol_multi <= viol_multi + 1;
      if (!busy) phase <= '0;
      if (stb != '0 && prev_stb == '0) begin
        if (ack_lvl && !stuck_lo && !stuck_hi) viol_ord <= viol_ord + 1;
        cnt  <= int'($urandom_range(0, 10));
        want <= 1'b1;
        if (stb[0]) begin
          phase <= 2'd1; lat_addr <= phy_ctl[15:0];
        end else if (stb[1]) begin
          if (phase != 2'd1) viol_ord <= viol_ord + 1;
          phase <= 2'd2; lat_wdat <= phy_ctl[15:0];
        end else if (stb[2]) begin
          if (phase != 2'd2) viol_ord <= viol_ord + 1;
          phy_mem[lat_addr[7:0]] <= lat_wdat; txn <= txn + 1; phase <= '0;
        end else begin
          if (phase != 2'd1) viol_ord <= viol_ord + 1;
          rd_val <= phy_mem[lat_addr[7:0]]; txn <= txn + 1; phase <= '0;
        end
      end else if (stb == '0 && prev_stb != '0) begin
        cnt  <= int'($urandom_range(0, 10));
        want <= 1'b0;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
      end else begin
        ack_lvl <= want;
      end
    end
  end

  always @(posedge clk) if (!rst && done) ndone <= ndone + 1;
  initial ndone = 0;

  // ---------------- checking ----------------
  int          n_chk = 0, n_fail = 0;
  logic [15:0] exp_mem [0:255];
  initial for (int i = 0; i < 256; i++) exp_mem[i] = 16'h1000 + 16'(i * 7);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk(done, "R8", "done seen", 32'(done), 32'd1);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", 32'(done), 32'd0);
  endtask

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    return exp_mem[a[7:0]];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc, t0, d0;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(phy_ctl == '0, "R9", "ctl after reset", 32'(phy_ctl), 32'd0);
    chk(!busy && !done && !timed_out, "R9", "flags after reset",
        {29'd0, busy, done, timed_out}, 32'd0);

    // directed write then read back
    do_op(1'b1, 16'h0005, 16'hA5A5, cyc);
    exp_mem[5] = 16'hA5A5;
    chk(!timed_out, "R3", "write no timeout", 32'(timed_out), 32'd0);
    chk(lat_addr == 16'h0005, "R2", "captured address", 32'(lat_addr), 32'h5);
    chk(lat_wdat == 16'hA5A5, "R3", "captured data", 32'(lat_wdat), 32'hA5A5);
    chk(phy_ctl == '0, "R3", "ctl zero after write", 32'(phy_ctl), 32'd0);
    do_op(1'b0, 16'h0005, 16'h0, cyc);
    chk(rd_data == exp_read(16'h5), "R4", "read back", 32'(rd_data), 32'(exp_read(16'h5)));
    chk(phy_ctl == '0, "R4", "ctl zero after read", 32'(phy_ctl), 32'd0);

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      logic [15:0] a, d;
      bit w;
      a = 16'($urandom_range(0, 15)) | (16'($urandom_range(0, 255)) << 8);
      d = 16'($urandom);
      w = 1'($urandom_range(0, 1));
      do_op(w, a, d, cyc);
      if (w) begin
        exp_mem[a[7:0]] = d;
        chk(!timed_out && lat_wdat == d, "R3", "random write", 32'(lat_wdat), 32'(d));
      end else begin
        chk(!timed_out && rd_data == exp_read(a), "R4", "random read",
            32'(rd_data), 32'(exp_read(a)));
      end
      chk(lat_addr == a, "R2", "random address", 32'(lat_addr), 32'(a));
    end

    // request while busy is dropped
    t0 = txn; d0 = ndone;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0003; req_wdata = 16'h3C3C;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0009;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (300) @(negedge clk);
    exp_mem[3] = 16'h3C3C;
    chk(!busy, "R7", "idle after one access", 32'(busy), 32'd0);
    chk(txn == t0 + 1, "R7", "single PHY access", 32'(txn), 32'(t0 + 1));
    chk(ndone == d0 + 1, "R7", "single done", 32'(ndone), 32'(d0 + 1));
    chk(lat_addr == 16'h0003, "R7", "busy request ignored", 32'(lat_addr), 32'h3);

    // ack stuck low: capture-address never acknowledged
    stuck_lo = 1'b1;
    t0 = txn;
    do_op(1'b1, 16'h0007, 16'h7777, cyc);
    chk(timed_out, "R6", "timeout flag", 32'(timed_out), 32'd1);
    chk(phy_ctl == '0 && !busy, "R6", "abort to idle", {11'd0, busy, phy_ctl}, 32'd0);
    chk(txn == t0, "R6", "no commit on abort", 32'(txn), 32'(t0));
    chk(cyc >= GAP * LIM - 2 && cyc <= GAP * LIM + 2, "R5", "abort time",
        32'(cyc), 32'(GAP * LIM));
    stuck_lo = 1'b0;
    repeat (40) @(negedge clk);
    chk(timed_out, "R8", "flag held while idle", 32'(timed_out), 32'd1);

    // ack stuck high: release phase never completes
    stuck_hi = 1'b1;
    repeat (4) @(negedge clk);
    do_op(1'b0, 16'h0002, 16'h0, cyc);
    chk(timed_out && phy_ctl == '0, "R6", "stuck-high timeout", 32'(timed_out), 32'd1);
    stuck_hi = 1'b0;
    repeat (40) @(negedge clk);

    // next good access clears the flag
    do_op(1'b0, 16'h0003, 16'h0, cyc);
    chk(!timed_out, "R8", "flag cleared", 32'(timed_out), 32'd0);
    chk(rd_data == exp_read(16'h3), "R4", "read after abort", 32'(rd_data),
        32'(exp_read(16'h3)));

    chk(viol_multi == 0, "R1", "single strobe", 32'(viol_multi), 32'd0);
    chk(viol_ord == 0, "R1", "strobe ordering", 32'(viol_ord), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule